// File: doc/BRIEF.md
# External Interrupt Edge Port

This block serves seven external pins, numbered 1 to 7. Software sets up each pin through a small register bank. A pin can be a general-purpose input, a general-purpose output with its own output enable, or an interrupt source. An interrupt source senses one of four conditions: low level, rising edge, falling edge, or either edge. Each pin has its own interrupt request line, which goes to a separate interrupt controller.

Each pin input passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one cycle earlier. An edge that matches the pin's sensing mode sets a sticky flag. Software clears the flag by writing 1 to its bit. In an edge mode the request follows the flag. In low-level mode no flag is latched, and the request follows the inverted synchronized pin. A pin asserts its request only when its enable bit is set.

The register bank has one write port and a combinational read port, selected by a 3-bit address: 0 sense-mode, 1 direction, 2 interrupt enable, 3 output data, 4 pin data (read-only), 5 flags. Addresses 6 and 7 read as zero. Bit n of every one-bit-per-pin register belongs to pin n, and bit 0 always reads 0.

Top module: `ext_irq_port`

## Requirements
- R1: After reset every register reads 0 and every request and output enable is low.
- R2: A direction bit of 1 drives that pin's output enable high, and the pin's output carries the output data bit. A direction bit of 0 leaves the pin as an input.
- R3: The pin-data register (address 4) returns the pin inputs two clock edges after they change, at bits 7:1.
- R4: The sense-mode field of pin n sits at bits 2n+1:2n of address 0. The codes are 2'b00 low level, 2'b01 rising edge, 2'b10 falling edge and 2'b11 either edge.
- R5: An edge that matches the pin's mode sets its flag bit at address 5, and an edge that does not match sets nothing.
- R6: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R7: When a new edge arrives in the same cycle as a clearing write to that flag, the flag stays set.
- R8: In low-level mode no flag is latched, and the enabled request is high exactly while the synchronized pin is low.
- R9: A pin whose enable bit is 0 never requests, but its flag still latches.
- R10: In an edge mode the enabled request equals the pin's flag.
- R11: The sense-mode, direction, enable and output-data registers read back what was written, with pin-0 bits reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register select for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| pinIn | input | 7 | Pin inputs, bit n is pin n |
| pinOut | output | 7 | Pin output values |
| pinOe | output | 7 | Pin output enables |
| irqReq | output | 7 | Interrupt request for each pin |

## Verification
The bench first drives all pins from high to low, then from low to high. For each transition it sets a different mode on each pin, so the one flag pattern shows which modes respond to falling edges, to rising edges, or to both. Directed steps set the enable bits to zero and then back to one, write all-zero and single-bit clear masks, and collide a clearing write with a fresh edge, to tell gating, sticky hold and set-priority apart. Random pin patterns, random modes, random enables and random clear masks are then checked against a model of flags and requests. This covers mixes of level and edge pins that the directed steps do not reach.

// File: rtl/eip_pkg.sv
package eip_pkg;

  typedef enum logic [2:0] {
    ADDR_MODE = 3'd0,
    ADDR_DIR  = 3'd1,
    ADDR_IEN  = 3'd2,
    ADDR_OUT  = 3'd3,
    ADDR_PIN  = 3'd4,
    ADDR_FLAG = 3'd5
  } eipAddr_e;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } eipSense_e;

  typedef struct packed {
    logic wrMode;
    logic wrDir;
    logic wrIen;
    logic wrOut;
    logic wrFlag;
  } eipStrobe_t;

endpackage

// File: rtl/eip_ctrl.sv
module eip_ctrl
  import eip_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int MODE_W = 16
) (
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [MODE_W-1:0] modeQ,
  input  logic [REG_W-1:0]  dirQ,
  input  logic [REG_W-1:0]  ienQ,
  input  logic [REG_W-1:0]  outQ,
  input  logic [REG_W-1:0]  pinData,
  input  logic [REG_W-1:0]  flagQ,
  output eipStrobe_t        strobe,
  output logic [MODE_W-1:0] rdData
);

  always_comb begin
    strobe = '0;
    rdData = '0;
    case (eipAddr_e'(addr))
      ADDR_MODE: begin
        strobe.wrMode = wrEn;
        rdData        = modeQ;
      end
      ADDR_DIR: begin
        strobe.wrDir = wrEn;
        rdData       = MODE_W'(dirQ);
      end
      ADDR_IEN: begin
        strobe.wrIen = wrEn;
        rdData       = MODE_W'(ienQ);
      end
      ADDR_OUT: begin
        strobe.wrOut = wrEn;
        rdData       = MODE_W'(outQ);
      end
      ADDR_PIN: rdData = MODE_W'(pinData);
      ADDR_FLAG: begin
        strobe.wrFlag = wrEn;
        rdData        = MODE_W'(flagQ);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/eip_datapath.sv
module eip_datapath
  import eip_pkg::*;
#(
  parameter int NUM_PINS = 7,
  parameter int REG_W    = NUM_PINS + 1,
  parameter int MODE_W   = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  eipStrobe_t        strobe,
  input  logic [MODE_W-1:0] wrData,
  input  logic [NUM_PINS:1] pinIn,
  output logic [MODE_W-1:0] modeQ,
  output logic [REG_W-1:0]  dirQ,
  output logic [REG_W-1:0]  ienQ,
  output logic [REG_W-1:0]  outQ,
  output logic [REG_W-1:0]  pinData,
  output logic [REG_W-1:0]  flagQ,
  output logic [NUM_PINS:1] pinOut,
  output logic [NUM_PINS:1] pinOe,
  output logic [NUM_PINS:1] irqReq
);

  localparam logic [REG_W-1:0]  PIN_MASK  = {{NUM_PINS{1'b1}}, 1'b0};
  localparam logic [MODE_W-1:0] MODE_MASK = {{(2*NUM_PINS){1'b1}}, 2'b00};

  logic [REG_W-1:0] edgeHit;
  logic [REG_W-1:0] flagNext;
  logic [REG_W-1:0] clrMask;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      dirQ  <= '0;
      ienQ  <= '0;
      outQ  <= '0;
    end else begin
      if (strobe.wrMode) modeQ <= wrData & MODE_MASK;
      if (strobe.wrDir)  dirQ  <= wrData[REG_W-1:0] & PIN_MASK;
      if (strobe.wrIen)  ienQ  <= wrData[REG_W-1:0] & PIN_MASK;
      if (strobe.wrOut)  outQ  <= wrData[REG_W-1:0] & PIN_MASK;
    end
  end

  assign pinOe  = dirQ[NUM_PINS:1];
  assign pinOut = outQ[NUM_PINS:1];

  // per-pin synchronizer, edge detection and request
  assign pinData[0] = 1'b0;
  assign edgeHit[0] = 1'b0;

  for (genvar g = 1; g <= NUM_PINS; g++) begin : gPin
    logic      syncA, syncB, prevB;
    eipSense_e sense;
    logic      riseEv, fallEv;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        prevB <= 1'b0;
      end else begin
        syncA <= pinIn[g];
        syncB <= syncA;
        prevB <= syncB;
      end
    end

    assign sense  = eipSense_e'(modeQ[2*g +: 2]);
    assign riseEv = syncB & ~prevB;
    assign fallEv = ~syncB & prevB;

    always_comb begin
      case (sense)
        SENSE_RISE: edgeHit[g] = riseEv;
        SENSE_FALL: edgeHit[g] = fallEv;
        SENSE_BOTH: edgeHit[g] = riseEv | fallEv;
        default:    edgeHit[g] = 1'b0;
      endcase
    end

    assign pinData[g] = syncB;
    assign irqReq[g]  = ienQ[g] & ((sense == SENSE_LOW) ? ~syncB : flagQ[g]);
  end

  // sticky flags: a fresh edge wins over a clearing write
  assign clrMask  = strobe.wrFlag ? wrData[REG_W-1:0] : '0;
  assign flagNext = (flagQ & ~clrMask) | edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext & PIN_MASK;
  end

endmodule

// File: rtl/ext_irq_port.sv
module ext_irq_port
  import eip_pkg::*;
#(
  parameter int NUM_PINS = 7,
  localparam int REG_W   = NUM_PINS + 1,
  localparam int DATA_W  = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_PINS:1] pinIn,
  output logic [NUM_PINS:1] pinOut,
  output logic [NUM_PINS:1] pinOe,
  output logic [NUM_PINS:1] irqReq
);

  eipStrobe_t        strobe;
  logic [DATA_W-1:0] modeCfg;
  logic [REG_W-1:0]  dirCfg, ienCfg, outCfg, pinData, flagCfg;

  eip_ctrl #(.REG_W(REG_W), .MODE_W(DATA_W)) ctrl_i (
    .wrEn    (wrEn),
    .addr    (addr),
    .modeQ   (modeCfg),
    .dirQ    (dirCfg),
    .ienQ    (ienCfg),
    .outQ    (outCfg),
    .pinData (pinData),
    .flagQ   (flagCfg),
    .strobe  (strobe),
    .rdData  (rdData)
  );

  eip_datapath #(.NUM_PINS(NUM_PINS), .REG_W(REG_W), .MODE_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .modeQ   (modeCfg),
    .dirQ    (dirCfg),
    .ienQ    (ienCfg),
    .outQ    (outCfg),
    .pinData (pinData),
    .flagQ   (flagCfg),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irqReq  (irqReq)
  );

endmodule

// File: rtl/ext_irq_port_chk.sv
module ext_irq_port_chk #(
  parameter int NUM_PINS = 7,
  localparam int REG_W   = NUM_PINS + 1,
  localparam int DATA_W  = 2 * REG_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] modeCfg,
  input logic [REG_W-1:0]  ienCfg,
  input logic [REG_W-1:0]  pinData,
  input logic [REG_W-1:0]  flagCfg,
  input logic [NUM_PINS:1] pinOe,
  input logic [NUM_PINS:1] irqReq
);

  logic [REG_W-1:0] lvlMask;
  logic [REG_W-1:0] clrSeen;

  for (genvar g = 0; g < REG_W; g++) begin : gLvl
    assign lvlMask[g] = (modeCfg[2*g +: 2] == 2'b00);
  end

  assign clrSeen = (wrEn && addr == 3'd5) ? wrData[REG_W-1:0] : '0;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flagCfg) & ~flagCfg & ~$past(clrSeen)) == '0)); // R6

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((flagCfg & ~$past(flagCfg) & $past(lvlMask)) == '0)); // R8

  AST_LEVEL_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (((irqReq ^ ~pinData[NUM_PINS:1]) & ienCfg[NUM_PINS:1] & lvlMask[NUM_PINS:1]) == '0)); // R8

  AST_EDGE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (((irqReq ^ flagCfg[NUM_PINS:1]) & ienCfg[NUM_PINS:1] & ~lvlMask[NUM_PINS:1]) == '0)); // R10

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((irqReq & ~ienCfg[NUM_PINS:1]) == '0)); // R9

  AST_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd1) |=> (pinOe == $past(wrData[NUM_PINS:1]))); // R2

endmodule

bind ext_irq_port ext_irq_port_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .modeCfg (modeCfg),
  .ienCfg  (ienCfg),
  .pinData (pinData),
  .flagCfg (flagCfg),
  .pinOe   (pinOe),
  .irqReq  (irqReq)
);

// File: tb/ext_irq_port_tb_top.sv
`timescale 1ns/1ps
module ext_irq_port_tb_top;

  localparam int NP = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [NP:1] pinIn = '0;
  logic [NP:1] pinOut, pinOe, irqReq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  ext_irq_port #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqReq(irqReq)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // bench model: flags raised by a pin transition under a given mode word
  function automatic logic [7:0] edgeFlags(input logic [NP:1] oldP, input logic [NP:1] newP,
                                           input logic [15:0] mode);
    logic [7:0] r = '0;
    for (int n = 1; n <= NP; n++) begin
      logic [1:0] m = mode[2*n +: 2];
      logic rise = ~oldP[n] & newP[n];
      logic fall = oldP[n] & ~newP[n];
      r[n] = (m == 2'b01 && rise) || (m == 2'b10 && fall) || (m == 2'b11 && (rise || fall));
    end
    return r;
  endfunction

  function automatic logic [NP:1] expIrq(input logic [NP:1] p, input logic [15:0] mode,
                                         input logic [7:0] ien, input logic [7:0] flg);
    logic [NP:1] r;
    for (int n = 1; n <= NP; n++)
      r[n] = ien[n] & ((mode[2*n +: 2] == 2'b00) ? ~p[n] : flg[n]);
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] mode;
    logic [7:0]  flg, ien;
    logic [NP:1] oldP, newP;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), d);
      check($sformatf("R1 reg%0d", a), d, 16'h0);
    end
    check("R1 irq", 16'(irqReq), 16'h0);
    check("R1 oe", 16'(pinOe), 16'h0);

    // R11 read back with pin-0 bits masked
    writeReg(3'd0, 16'hA5A7); readReg(3'd0, d); check("R11 mode", d, 16'hA5A4);
    writeReg(3'd1, 16'h00FF); readReg(3'd1, d); check("R11 dir", d, 16'h00FE);
    writeReg(3'd2, 16'h0033); readReg(3'd2, d); check("R11 ien", d, 16'h0032);
    writeReg(3'd3, 16'h0055); readReg(3'd3, d); check("R11 out", d, 16'h0054);
    writeReg(3'd2, 16'h0000);

    // R2 direction and output data
    writeReg(3'd1, 16'h000A);
    writeReg(3'd3, 16'h00FE);
    check("R2 oe", 16'(pinOe), 16'h0005);
    check("R2 out", 16'(pinOut), 16'h007F);
    writeReg(3'd1, 16'h0000);
    check("R2 input", 16'(pinOe), 16'h0000);

    // R3 pin data
    pinIn = 7'h55;
    settle();
    readReg(3'd4, d); check("R3 pins", d, 16'h00AA);

    // R4/R5 modes: pin1 low, 2 rise, 3 fall, 4 both, 5 rise, 6 fall, 7 both
    mode = {2'b11, 2'b10, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00, 2'b00};
    pinIn = '1;
    writeReg(3'd0, mode);
    settle();
    writeReg(3'd5, 16'h00FF);
    readReg(3'd5, d); check("R6 cleared", d, 16'h0000);
    pinIn = '0;
    settle();
    readReg(3'd5, d); check("R4 falling set", d, 16'h00D8);
    check("R9 no irq while disabled", 16'(irqReq), 16'h0000);
    writeReg(3'd5, 16'h00FF);
    pinIn = '1;
    settle();
    readReg(3'd5, d); check("R5 rising set", d, 16'h00B4);

    // R9/R10/R8 enable all
    writeReg(3'd2, 16'h00FE);
    check("R10 irq follows flags", 16'(irqReq), 16'h005A);
    pinIn[1] = 1'b0;
    settle();
    check("R8 level low requests", 16'(irqReq), 16'h005B);
    readReg(3'd5, d); check("R8 no flag latched", d, 16'h00B4);
    pinIn[1] = 1'b1;
    settle();
    check("R8 level released", 16'(irqReq), 16'h005A);

    // R6 write-0 no effect, single-bit clear
    writeReg(3'd5, 16'h0000);
    readReg(3'd5, d); check("R6 write zero", d, 16'h00B4);
    writeReg(3'd5, 16'h0010);
    readReg(3'd5, d); check("R6 clear bit4", d, 16'h00A4);

    // R7 edge collides with clear on pin2 (rise mode, flag already set)
    pinIn[2] = 1'b0;
    settle();
    @(negedge clk) pinIn[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'd5; wrData = 16'h0004;
    @(negedge clk);
    wrEn = 1'b0;
    readReg(3'd5, d); check("R7 set wins", d, 16'h00A4);

    // random phase against model
    writeReg(3'd5, 16'h00FF);
    flg = '0; oldP = pinIn; ien = 8'hFE;
    for (int it = 0; it < 200; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        mode = 16'($urandom) & 16'hFFFC;
        writeReg(3'd0, mode);
      end
      if ($urandom_range(0, 3) == 0) begin
        ien = 8'($urandom) & 8'hFE;
        writeReg(3'd2, {8'h00, ien});
      end
      newP = NP'($urandom);
      pinIn = newP;
      flg = flg | edgeFlags(oldP, newP, mode);
      oldP = newP;
      settle();
      readReg(3'd5, d); check("R5 random flags", d, {8'h00, flg});
      check("R10 random irq", 16'(irqReq), 16'(expIrq(oldP, mode, ien, flg)));
      if ($urandom_range(0, 2) == 0) begin
        d = 16'($urandom) & 16'h00FE;
        writeReg(3'd5, d);
        flg = flg & ~d[7:0];
        readReg(3'd5, d); check("R6 random clear", d, {8'h00, flg});
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule